// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a watchdog that counts enable pulses from a slow oscillator and asks for a system reset when software stops servicing it. It can also ask for a reset when software services it too early, or when software services it with the wrong key. An 8-bit configuration byte sets its behaviour. The byte is taken once, on the first clock edge after reset is released, and is held until the next reset. The byte selects four things:

- whether the watchdog runs at all;
- the overflow period, a power of two from a table that skips some exponents;
- the part of the period during which a restart is accepted;
- whether the count keeps running while the core is in HALT or STOP.

Software restarts the count by writing a key byte to the restart port. A restart is accepted only while the window is open. The window opens late in each period and stays open until overflow.

Top module: `winwdog_top`

## Requirements
- R1: The configuration byte is latched on the first rising clock edge after `rstN` is released. Changes to `cfgByte` after that edge have no effect until the next reset.
- R2: When configuration bit 4 is 0, the counter does not run and `rstReq` never rises. Restart writes, including wrong keys, are ignored. When bit 4 is 1, counting starts right after the latch edge.
- R3: Bits 3:1 select the period as 2^N counted ticks, with N = 7, 8, 9, 10, 12, 14, 15, 17 for codes 0 to 7. On the tick that would make the count reach the period, `rstReq` is high for the following cycle and the count restarts from 0.
- R4: Bits 6:5 select the open part of the period: code 0 gives the last quarter, 1 the last half, 2 the last three quarters, and 3 the whole period. The window is open once the count is at least period × (3 − code) / 4.
- R5: A write of 0xAC while the window is open clears the count to 0 and raises no reset request. The next overflow is then a full period after the write.
- R6: A write of any value while the window is closed raises `rstReq` in the cycle after the write. So does a write of any value other than 0xAC while the window is open.
- R7: When bit 0 is 0, no tick is counted while `haltMode` or `stopMode` is high. When bit 0 is 1, these inputs have no effect on counting.
- R8: `cfgErr` goes high after the latch edge if bit 7 is 1, or if bits 3:1 and bits 6:5 are both zero. While `cfgErr` is high, the window is treated as the last quarter whatever bits 6:5 hold.
- R9: While `rstN` is low, `rstReq` and `cfgErr` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgByte | input | 8 | Configuration byte, taken on the first edge after reset |
| slowTick | input | 1 | One-cycle enable pulse from the slow oscillator |
| haltMode | input | 1 | Core is in HALT |
| stopMode | input | 1 | Core is in STOP |
| wrValid | input | 1 | Restart register write strobe |
| wrData | input | 8 | Restart register write data |
| rstReq | output | 1 | Reset request, one cycle per event |
| cfgErr | output | 1 | Configuration byte is illegal |

## Verification
The bench holds `slowTick` high. Call the configuration-latch edge edge 0. After edge k the count is k, so a write presented before edge k is judged at count k − 1. Every result (`rstReq` from an overflow or a bad write, and the clear from a good restart) is registered and appears right after the edge that sees its cause. The bench counts edges from the latch edge and samples every output on the falling edge after the edge where the result is due. It also samples one edge before that, where the output must still be low. HALT and STOP stalls are counted as edges during which the count does not advance, so the overflow edge moves by exactly the stall length.

// File: rtl/winwdog_pkg.sv
package winwdog_pkg;

  // Largest period exponent and the counter width it needs
  localparam int MAX_SHIFT = 17;
  localparam int CNT_W     = MAX_SHIFT;
  localparam int CFG_W     = 8;

  // Configuration byte field positions
  localparam int CLKFIX_BIT = 0;
  localparam int OVF_LO     = 1;
  localparam int OVF_HI     = 3;
  localparam int RUN_BIT    = 4;
  localparam int WIN_LO     = 5;
  localparam int WIN_HI     = 6;
  localparam int RSVD_BIT   = 7;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic inc;
    logic clr;
  } wdCmd_t;

  function automatic int unsigned periodShift(input logic [2:0] code);
    case (code)
      3'd0: return 7;
      3'd1: return 8;
      3'd2: return 9;
      3'd3: return 10;
      3'd4: return 12;
      3'd5: return 14;
      3'd6: return 15;
      default: return 17;
    endcase
  endfunction

endpackage

// File: rtl/winwdog_dp.sv
module winwdog_dp
  import winwdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wdCmd_t           cmd,
  input  logic [CFG_W-1:0] cfgIn,
  output logic             loaded,
  output logic             enabled,
  output logic             clkFix,
  output logic             cfgErr,
  output logic             winOpen,
  output logic             atLast
);

  localparam logic [CNT_W:0]   ONE_W = {{CNT_W{1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] STEP  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CFG_W-1:0] cfgReg;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       ovfCode;
  logic [1:0]       rawWin;
  logic [1:0]       winSel;
  logic             badCfg;
  int unsigned      shiftAmt;
  logic [CNT_W:0]   period;
  logic [CNT_W:0]   lastCnt;
  logic [CNT_W:0]   quarter;
  logic [CNT_W:0]   openStart;

  // Configuration register, written once after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loaded <= 1'b0;
      cfgReg <= '0;
    end else if (cmd.load) begin
      loaded <= 1'b1;
      cfgReg <= cfgIn;
    end
  end

  // Field decode
  always_comb begin
    ovfCode   = cfgReg[OVF_HI:OVF_LO];
    rawWin    = cfgReg[WIN_HI:WIN_LO];
    badCfg    = cfgReg[RSVD_BIT] | ((ovfCode == 3'd0) && (rawWin == 2'd0));
    winSel    = badCfg ? 2'd0 : rawWin;
    shiftAmt  = periodShift(ovfCode);
    period    = ONE_W << shiftAmt;
    lastCnt   = period - ONE_W;
    quarter   = period >> 2;
    case (winSel)
      2'd0:    openStart = quarter + (quarter << 1);
      2'd1:    openStart = quarter << 1;
      2'd2:    openStart = quarter;
      default: openStart = '0;
    endcase
  end

  assign enabled = cfgReg[RUN_BIT];
  assign clkFix  = cfgReg[CLKFIX_BIT];
  assign cfgErr  = loaded & badCfg;
  assign winOpen = {1'b0, cnt} >= openStart;
  assign atLast  = {1'b0, cnt} == lastCnt;

  // Tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (cmd.clr) cnt <= '0;
    else if (cmd.inc) cnt <= cnt + STEP;
  end

  // R1
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(loaded) |-> $stable(cfgReg));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + STEP) || (cnt == '0)));

endmodule

// File: rtl/winwdog_ctrl.sv
module winwdog_ctrl
  import winwdog_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESTART_CODE = 8'hAC
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loaded,
  input  logic             enabled,
  input  logic             clkFix,
  input  logic             winOpen,
  input  logic             atLast,
  input  logic             slowTick,
  input  logic             haltMode,
  input  logic             stopMode,
  input  logic             wrValid,
  input  logic [CFG_W-1:0] wrData,
  output wdCmd_t           cmd,
  output logic             rstReq
);

  logic active;
  logic clkOk;
  logic codeOk;
  logic restartOk;
  logic badWrite;
  logic overflow;

  always_comb begin
    active    = loaded & enabled;
    clkOk     = clkFix | ~(haltMode | stopMode);
    codeOk    = (wrData == RESTART_CODE);
    restartOk = active & wrValid & codeOk & winOpen;
    badWrite  = active & wrValid & ~(codeOk & winOpen);
    cmd.load  = ~loaded;
    cmd.inc   = active & slowTick & clkOk & ~restartOk;
    overflow  = cmd.inc & atLast;
    cmd.clr   = restartOk | overflow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstReq <= 1'b0;
    else       rstReq <= overflow | badWrite;
  end

  // R2
  run_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(loaded && enabled));

  // R5
  good_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(loaded && enabled && wrValid && wrData == RESTART_CODE && winOpen) |-> !rstReq);

  // R6
  closed_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(loaded && enabled && wrValid && !winOpen) |-> rstReq);

  // R7
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkFix && (haltMode || stopMode)) |-> !cmd.inc);

endmodule

// File: rtl/winwdog_top.sv
module winwdog_top
  import winwdog_pkg::*;
#(
  parameter logic [7:0] RESTART_CODE = 8'hAC
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] cfgByte,
  input  logic       slowTick,
  input  logic       haltMode,
  input  logic       stopMode,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  output logic       rstReq,
  output logic       cfgErr
);

  wdCmd_t cmd;
  logic   loaded;
  logic   enabled;
  logic   clkFix;
  logic   winOpen;
  logic   atLast;

  winwdog_ctrl #(.RESTART_CODE(RESTART_CODE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loaded   (loaded),
    .enabled  (enabled),
    .clkFix   (clkFix),
    .winOpen  (winOpen),
    .atLast   (atLast),
    .slowTick (slowTick),
    .haltMode (haltMode),
    .stopMode (stopMode),
    .wrValid  (wrValid),
    .wrData   (wrData),
    .cmd      (cmd),
    .rstReq   (rstReq)
  );

  winwdog_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .cfgIn   (cfgByte),
    .loaded  (loaded),
    .enabled (enabled),
    .clkFix  (clkFix),
    .cfgErr  (cfgErr),
    .winOpen (winOpen),
    .atLast  (atLast)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!rstReq && !cfgErr));

endmodule

// File: tb/winwdog_top_tb.sv
`timescale 1ns/1ps
module winwdog_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] cfgByte = 8'h00;
  logic       slowTick = 1'b1;
  logic       haltMode = 1'b0;
  logic       stopMode = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rstReq;
  logic       cfgErr;

  int checks = 0;
  int fails  = 0;
  int curEdge;

  always #4 clk = ~clk;

  winwdog_top u_dut (
    .clk(clk), .rstN(rstN), .cfgByte(cfgByte), .slowTick(slowTick),
    .haltMode(haltMode), .stopMode(stopMode), .wrValid(wrValid),
    .wrData(wrData), .rstReq(rstReq), .cfgErr(cfgErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reset and release; the next posedge (edge 0) latches the configuration
  task automatic startCfg(input logic [7:0] cfg);
    @(negedge clk);
    rstN = 1'b0; wrValid = 1'b0; haltMode = 1'b0; stopMode = 1'b0;
    cfgByte = cfg;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curEdge = -1;
  endtask

  // Advance to the falling edge after edge k
  task automatic stepTo(input int k);
    while (curEdge < k) begin
      @(posedge clk);
      @(negedge clk);
      curEdge++;
    end
  endtask

  // Check rstReq stays low on every edge up to k
  task automatic quietTo(input int k, input string tag);
    int highs = 0;
    while (curEdge < k) begin
      stepTo(curEdge + 1);
      if (rstReq) highs++;
    end
    chk(highs == 0, tag, highs, 0);
  endtask

  // Present a write judged at edge k
  task automatic writeAt(input int k, input logic [7:0] val);
    stepTo(k - 1);
    wrValid = 1'b1; wrData = val;
    stepTo(k);
    wrValid = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0; cfgByte = 8'h71;
    repeat (2) @(negedge clk);
    chk(rstReq == 1'b0, "R9 rstReq in reset", rstReq, 0);
    chk(cfgErr == 1'b0, "R9 cfgErr in reset", cfgErr, 0);
  endtask

  task automatic testOverflow();
    startCfg(8'h71);           // run, code 0 (128), window 100%, clock fixed
    stepTo(0);
    cfgByte = 8'h13;           // late change must be ignored
    chk(cfgErr == 1'b0, "R8 legal byte no error", cfgErr, 0);
    quietTo(127, "R3 no early overflow");
    stepTo(128);
    chk(rstReq == 1'b1, "R3 overflow at 128 (R1 latched)", rstReq, 1);
    stepTo(129);
    chk(rstReq == 1'b0, "R3 one-cycle pulse", rstReq, 0);
    quietTo(255, "R3 restart quiet");
    stepTo(256);
    chk(rstReq == 1'b1, "R3 second overflow", rstReq, 1);
  endtask

  task automatic testPeriods();
    startCfg(8'h77);           // code 3 -> 1024
    stepTo(1023);
    chk(rstReq == 1'b0, "R3 code3 before", rstReq, 0);
    stepTo(1024);
    chk(rstReq == 1'b1, "R3 code3 at 1024", rstReq, 1);
    startCfg(8'h79);           // code 4 -> 4096
    quietTo(4095, "R3 code4 before");
    stepTo(4096);
    chk(rstReq == 1'b1, "R3 code4 at 4096", rstReq, 1);
  endtask

  task automatic testWindowQuarter();
    startCfg(8'h13);           // 256, last quarter opens at 192
    writeAt(192, 8'hAC);       // count 191
    chk(rstReq == 1'b1, "R6 key at 191 closed", rstReq, 1);
    startCfg(8'h13);
    writeAt(193, 8'hAC);       // count 192
    chk(rstReq == 1'b0, "R5 key at 192 open", rstReq, 0);
    quietTo(448, "R5 count cleared");
    stepTo(449);
    chk(rstReq == 1'b1, "R5 full period after restart", rstReq, 1);
  endtask

  task automatic testWindowOthers();
    startCfg(8'h53);           // 75%: opens at 64
    writeAt(64, 8'hAC);
    chk(rstReq == 1'b1, "R4 75% closed at 63", rstReq, 1);
    startCfg(8'h53);
    writeAt(65, 8'hAC);
    chk(rstReq == 1'b0, "R4 75% open at 64", rstReq, 0);
    startCfg(8'h33);           // 50%: opens at 128
    writeAt(128, 8'hAC);
    chk(rstReq == 1'b1, "R4 50% closed at 127", rstReq, 1);
    startCfg(8'h33);
    writeAt(129, 8'hAC);
    chk(rstReq == 1'b0, "R4 50% open at 128", rstReq, 0);
  endtask

  task automatic testBadKey();
    startCfg(8'h73);           // 256, window 100%
    writeAt(11, 8'h55);
    chk(rstReq == 1'b1, "R6 wrong key open window", rstReq, 1);
    stepTo(12);
    chk(rstReq == 1'b0, "R6 pulse ends", rstReq, 0);
  endtask

  task automatic testDisabled();
    startCfg(8'h03);
    quietTo(299, "R2 disabled no overflow");
    writeAt(300, 8'h55);
    chk(rstReq == 1'b0, "R2 disabled write ignored", rstReq, 0);
    quietTo(310, "R2 disabled stays quiet");
  endtask

  task automatic testSleep();
    startCfg(8'h70);           // stoppable clock, 128
    stepTo(20);
    haltMode = 1'b1;
    stepTo(70);
    haltMode = 1'b0;
    quietTo(177, "R7 halt stalls count");
    stepTo(178);
    chk(rstReq == 1'b1, "R7 overflow delayed 50", rstReq, 1);
    startCfg(8'h71);           // clock cannot stop
    stepTo(20);
    haltMode = 1'b1;
    stepTo(127);
    chk(rstReq == 1'b0, "R7 fixed clock before", rstReq, 0);
    stepTo(128);
    chk(rstReq == 1'b1, "R7 halt ignored", rstReq, 1);
    haltMode = 1'b0;
    startCfg(8'h70);
    stepTo(30);
    stopMode = 1'b1;
    stepTo(40);
    stopMode = 1'b0;
    stepTo(137);
    chk(rstReq == 1'b0, "R7 stop before", rstReq, 0);
    stepTo(138);
    chk(rstReq == 1'b1, "R7 stop stalls 10", rstReq, 1);
  endtask

  task automatic testCfgErr();
    startCfg(8'h10);           // code 0 with window 0
    stepTo(0);
    chk(cfgErr == 1'b1, "R8 forbidden combination", cfgErr, 1);
    startCfg(8'hF3);           // bit 7 set, window bits say 100%
    stepTo(0);
    chk(cfgErr == 1'b1, "R8 reserved bit", cfgErr, 1);
    writeAt(101, 8'hAC);       // count 100 closed under forced 25%
    chk(rstReq == 1'b1, "R8 forced last quarter", rstReq, 1);
  endtask

  initial begin
    testReset();
    testOverflow();
    testPeriods();
    testWindowQuarter();
    testWindowOthers();
    testBadKey();
    testDisabled();
    testSleep();
    testCfgErr();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule